// File: doc/BRIEF.md
# Two-Channel Interrupt Status and Mask Unit

This block collects every interrupt condition of a serial block with two channels and reduces them to a single active-low interrupt line. Each channel supplies a transmit-ready level, a receive-ready/FIFO-full level and a one-cycle pulse when its received-break status changes. The block also takes a terminal-count pulse from the shared counter and an asynchronous general-purpose input pin. That pin passes through a synchroniser and an edge detector, so that any change of its state is reported.

All conditions are held in an eight-bit status register. The CPU sees this register unmasked. A CPU-writable mask register decides which status bits may pull the interrupt line low. A routing enable can also place the transmit-ready and receive-ready status of both channels directly on two multi-purpose pin outputs per channel pair, and the mask never gates these outputs. Reading the status register clears its event bits; a separate clear strobe does the same without a read.

Top module: `chan_pair_irq`

## Requirements
- R1: While `rstN` is low and after it rises: the status and mask registers are zero, `rdData` is zero, `intN` is high, and `mppTxOut`, `mppRxOut` and `mppOutEn` are zero.
- R2: Status bit layout: bit 0 is channel A transmit ready, bit 1 is channel A receive ready, bit 2 is channel A break change, bit 3 is counter terminal count, bit 4 is channel B transmit ready, bit 5 is channel B receive ready, bit 6 is channel B break change, and bit 7 is input-pin change. The ready bits follow `txRdyIn`/`rxRdyIn` one clock later.
- R3: A high `brkChgIn[c]` or `ctrTermIn` in a cycle sets its status bit at the next edge. The bit stays set until it is cleared.
- R4: A status read (`rdEn`=1, `regSel`=0) loads the pre-edge status into `rdData` one clock later and clears the sticky bits (2, 3, 6, 7). Ready bits are unaffected. An event in the same cycle as the read keeps its bit set.
- R5: A one-cycle `clrStb` clears all sticky status bits without changing `rdData`.
- R6: A write with `regSel`=1 loads `wrData` into the mask register. A read with `regSel`=1 returns the mask on `rdData` one clock later.
- R7: `intN` is low exactly when the status register AND the mask register is non-zero. It reflects a register update in the same cycle.
- R8: A status read returns every active condition whatever the mask holds.
- R9: With `pinRouteEn`=1, `mppOutEn` is 1, `mppTxOut[c]` equals channel c's transmit-ready status bit and `mppRxOut[c]` equals its receive-ready status bit, independent of the mask. With `pinRouteEn`=0 all three outputs are 0.
- R10: A rising or falling edge on `mpiPin` sets status bit 7 at the third clock edge after the change. A steady pin sets nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txRdyIn | input | 2 | Transmit-ready level per channel (bit 0 = A) |
| rxRdyIn | input | 2 | Receive-ready/FIFO-full level per channel |
| brkChgIn | input | 2 | One-cycle break-status-change pulse per channel |
| ctrTermIn | input | 1 | One-cycle counter terminal-count pulse |
| mpiPin | input | 1 | Asynchronous general-purpose input pin |
| regSel | input | 1 | Register select: 0 status, 1 mask |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe (mask only) |
| wrData | input | 8 | Write data |
| clrStb | input | 1 | Clear all sticky status bits |
| pinRouteEn | input | 1 | Route ready status to multi-purpose pins |
| rdData | output | 8 | Registered read data |
| intN | output | 1 | Active-low interrupt |
| mppTxOut | output | 2 | Routed transmit-ready status per channel |
| mppRxOut | output | 2 | Routed receive-ready status per channel |
| mppOutEn | output | 1 | Output enable for the routed pins |

## Verification
Ready levels, event pulses, mask writes and clear strobes act at the first clock edge after they are applied. Read data and `intN` are therefore due one edge after the stimulus, and pin routing is due the same cycle as the status it shows. An input-pin change is only due at the third edge, so the bench also confirms `intN` is still high after the first and second edges. The driver applies inputs at the falling edge and queues each expected value right after the rising edge where it is due. The monitor compares the queue a few nanoseconds after that same edge, so every check lands in exactly its due cycle.

// File: rtl/chan_pair_irq_pkg.sv
package chan_pair_irq_pkg;
  localparam int NUM_CH  = 2;
  localparam int SLOT_W  = 4;
  localparam int STAT_W  = NUM_CH * SLOT_W;
  localparam int OFS_TX  = 0;
  localparam int OFS_RX  = 1;
  localparam int OFS_BRK = 2;
  localparam int OFS_AUX = 3;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_MASK   = 1'b1
  } regSel_e;

  typedef struct packed {
    logic rdStatus;
    logic rdMask;
    logic wrMask;
    logic clrSticky;
    logic mpiEdge;
  } irqStb_t;
endpackage

// File: rtl/chan_pair_irq_ctrl.sv
module chan_pair_irq_ctrl
  import chan_pair_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    rdEn,
  input  logic    wrEn,
  input  logic    regSel,
  input  logic    clrStb,
  input  logic    mpiPin,
  output irqStb_t stb
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lastQ;

  // Synchroniser chain followed by one history flop for edge compare
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      lastQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], mpiPin};
      lastQ <= syncQ[TOP];
    end
  end

  always_comb begin
    stb.rdStatus  = rdEn & (regSel == SEL_STATUS);
    stb.rdMask    = rdEn & (regSel == SEL_MASK);
    stb.wrMask    = wrEn & (regSel == SEL_MASK);
    stb.clrSticky = clrStb;
    stb.mpiEdge   = syncQ[TOP] ^ lastQ;
  end

  // R10: a pin held steady through the whole chain produces no edge
  a_r10_steady_no_edge: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(mpiPin) && $stable(syncQ) && $stable(lastQ) && (syncQ[TOP] == lastQ))
      |=> !stb.mpiEdge)
    else $error("a_r10_steady_no_edge");
endmodule

// File: rtl/chan_pair_irq_dp.sv
module chan_pair_irq_dp
  import chan_pair_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] txRdyIn,
  input  logic [NUM_CH-1:0] rxRdyIn,
  input  logic [NUM_CH-1:0] brkChgIn,
  input  logic              ctrTermIn,
  input  irqStb_t           stb,
  input  logic [STAT_W-1:0] wrData,
  input  logic              pinRouteEn,
  output logic [STAT_W-1:0] rdData,
  output logic              intN,
  output logic [NUM_CH-1:0] mppTxOut,
  output logic [NUM_CH-1:0] mppRxOut,
  output logic              mppOutEn
);
  logic [STAT_W-1:0] statusQ;
  logic [STAT_W-1:0] statusD;
  logic [STAT_W-1:0] maskQ;
  logic [STAT_W-1:0] rdDataQ;
  logic [NUM_CH-1:0] auxEvt;
  logic              stickyClr;

  // Slot 3 of channel A carries the counter, slot 3 of channel B the pin change
  assign auxEvt    = {stb.mpiEdge, ctrTermIn};
  assign stickyClr = stb.rdStatus | stb.clrSticky;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_slot
    localparam int BASE = ch * SLOT_W;

    assign statusD[BASE+OFS_TX]  = txRdyIn[ch];
    assign statusD[BASE+OFS_RX]  = rxRdyIn[ch];
    assign statusD[BASE+OFS_BRK] = brkChgIn[ch] | (statusQ[BASE+OFS_BRK] & ~stickyClr);
    assign statusD[BASE+OFS_AUX] = auxEvt[ch]   | (statusQ[BASE+OFS_AUX] & ~stickyClr);

    assign mppTxOut[ch] = pinRouteEn & statusQ[BASE+OFS_TX];
    assign mppRxOut[ch] = pinRouteEn & statusQ[BASE+OFS_RX];

    // R2: ready bits track their level input one edge later
    a_r2_level_follow: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (statusQ[BASE+OFS_TX] == $past(txRdyIn[ch]))
            && (statusQ[BASE+OFS_RX] == $past(rxRdyIn[ch])))
      else $error("a_r2_level_follow");

    // R3: an event pulse always lands in its bit
    a_r3_event_sets: assert property (@(posedge clk) disable iff (!rstN)
      brkChgIn[ch] |=> statusQ[BASE+OFS_BRK])
      else $error("a_r3_event_sets");

    // R3: a sticky bit survives when nothing clears it
    a_r3_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
      (statusQ[BASE+OFS_BRK] && !stb.rdStatus && !stb.clrSticky) |=> statusQ[BASE+OFS_BRK])
      else $error("a_r3_sticky_hold");

    // R4: a read with no colliding event empties the sticky bit
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rstN)
      (stb.rdStatus && !brkChgIn[ch]) |=> !statusQ[BASE+OFS_BRK])
      else $error("a_r4_read_clears");
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
      rdDataQ <= '0;
    end else begin
      statusQ <= statusD;
      if (stb.wrMask) begin
        maskQ <= wrData;
      end
      if (stb.rdStatus) begin
        rdDataQ <= statusQ;
      end else if (stb.rdMask) begin
        rdDataQ <= maskQ;
      end
    end
  end

  assign rdData   = rdDataQ;
  assign intN     = ~|(statusQ & maskQ);
  assign mppOutEn = pinRouteEn;

  // R4: read data is the status seen before the read edge
  a_r4_read_returns: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdStatus |=> (rdData == $past(statusQ)))
    else $error("a_r4_read_returns");

  // R6: a mask write lands unchanged
  a_r6_mask_write: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrMask |=> (maskQ == $past(wrData)))
    else $error("a_r6_mask_write");
endmodule

// File: rtl/chan_pair_irq.sv
module chan_pair_irq
  import chan_pair_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] txRdyIn,
  input  logic [NUM_CH-1:0] rxRdyIn,
  input  logic [NUM_CH-1:0] brkChgIn,
  input  logic              ctrTermIn,
  input  logic              mpiPin,
  input  logic              regSel,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [STAT_W-1:0] wrData,
  input  logic              clrStb,
  input  logic              pinRouteEn,
  output logic [STAT_W-1:0] rdData,
  output logic              intN,
  output logic [NUM_CH-1:0] mppTxOut,
  output logic [NUM_CH-1:0] mppRxOut,
  output logic              mppOutEn
);
  irqStb_t stb;

  chan_pair_irq_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .rdEn   (rdEn),
    .wrEn   (wrEn),
    .regSel (regSel),
    .clrStb (clrStb),
    .mpiPin (mpiPin),
    .stb    (stb)
  );

  chan_pair_irq_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .txRdyIn    (txRdyIn),
    .rxRdyIn    (rxRdyIn),
    .brkChgIn   (brkChgIn),
    .ctrTermIn  (ctrTermIn),
    .stb        (stb),
    .wrData     (wrData),
    .pinRouteEn (pinRouteEn),
    .rdData     (rdData),
    .intN       (intN),
    .mppTxOut   (mppTxOut),
    .mppRxOut   (mppRxOut),
    .mppOutEn   (mppOutEn)
  );

  // R7: clearing the mask silences the interrupt on the next edge
  a_r7_zero_mask_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel && (wrData == '0)) |=> intN)
    else $error("a_r7_zero_mask_quiet");

  // R9: with routing off the pin outputs stay idle
  a_r9_route_off: assert property (@(posedge clk) disable iff (!rstN)
    !pinRouteEn |-> (mppOutEn == 1'b0) && (mppTxOut == '0) && (mppRxOut == '0))
    else $error("a_r9_route_off");
endmodule

// File: tb/chan_pair_irq_tb_top.sv
module chan_pair_irq_tb_top;
  typedef struct {
    string    tag;
    int       kind;
    logic [7:0] exp;
  } sbItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] txRdyIn = '0;
  logic [1:0] rxRdyIn = '0;
  logic [1:0] brkChgIn = '0;
  logic       ctrTermIn = 1'b0;
  logic       mpiPin = 1'b0;
  logic       regSel = 1'b0;
  logic       rdEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       clrStb = 1'b0;
  logic       pinRouteEn = 1'b0;
  logic [7:0] rdData;
  logic       intN;
  logic [1:0] mppTxOut;
  logic [1:0] mppRxOut;
  logic       mppOutEn;

  int      nChecks = 0;
  int      nFails = 0;
  bit      finished = 1'b0;
  sbItem_t sbQ[$];
  sbItem_t cur;
  logic [7:0] act;

  always #5 clk = ~clk;

  chan_pair_irq dut_i (
    .clk(clk), .rstN(rstN), .txRdyIn(txRdyIn), .rxRdyIn(rxRdyIn),
    .brkChgIn(brkChgIn), .ctrTermIn(ctrTermIn), .mpiPin(mpiPin),
    .regSel(regSel), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .clrStb(clrStb), .pinRouteEn(pinRouteEn), .rdData(rdData), .intN(intN),
    .mppTxOut(mppTxOut), .mppRxOut(mppRxOut), .mppOutEn(mppOutEn)
  );

  // kinds: 0 rdData, 1 intN, 2 {mppTxOut, mppRxOut}, 3 mppOutEn
  task automatic expectVal(input string tag, input int kind, input logic [7:0] exp);
    sbItem_t it;
    it.tag = tag; it.kind = kind; it.exp = exp;
    sbQ.push_back(it);
  endtask

  // Monitor: compare queued expectations a little after each rising edge
  always @(posedge clk) begin
    #3;
    while (sbQ.size() > 0) begin
      cur = sbQ.pop_front();
      case (cur.kind)
        0: act = rdData;
        1: act = {7'd0, intN};
        2: act = {4'd0, mppTxOut, mppRxOut};
        default: act = {7'd0, mppOutEn};
      endcase
      nChecks++;
      if (act !== cur.exp) begin
        nFails++;
        $display("FAIL %s kind %0d actual %02h expected %02h", cur.tag, cur.kind, act, cur.exp);
      end
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic readReg(input logic sel, input string tag, input logic [7:0] exp);
    @(negedge clk); regSel = sel; rdEn = 1'b1;
    @(posedge clk); expectVal(tag, 0, exp);
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic writeMask(input logic [7:0] val);
    @(negedge clk); regSel = 1'b1; wrEn = 1'b1; wrData = val;
    @(posedge clk);
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic setLevels(input logic [1:0] tx, input logic [1:0] rx);
    @(negedge clk); txRdyIn = tx; rxRdyIn = rx;
    @(posedge clk);
  endtask

  task automatic pulseBrk(input logic [1:0] which);
    @(negedge clk); brkChgIn = which;
    @(posedge clk);
    @(negedge clk); brkChgIn = '0;
  endtask

  task automatic pulseCtr();
    @(negedge clk); ctrTermIn = 1'b1;
    @(posedge clk);
    @(negedge clk); ctrTermIn = 1'b0;
  endtask

  task automatic pulseClr();
    @(negedge clk); clrStb = 1'b1;
    @(posedge clk);
    @(negedge clk); clrStb = 1'b0;
  endtask

  initial begin
    idle(20000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1 reset state
    idle(3);
    expectVal("R1", 0, 8'h00); expectVal("R1", 1, 8'h01);
    expectVal("R1", 2, 8'h00); expectVal("R1", 3, 8'h00);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk);
    expectVal("R1", 1, 8'h01);
    readReg(1'b0, "R1", 8'h00);
    readReg(1'b1, "R1", 8'h00);

    // R2 level bits and layout
    setLevels(2'b01, 2'b10);
    readReg(1'b0, "R2", 8'h21);
    setLevels(2'b10, 2'b01);
    readReg(1'b0, "R2", 8'h12);

    // R7 / R6 mask gating
    expectVal("R7", 1, 8'h01);
    writeMask(8'h10);
    expectVal("R7", 1, 8'h00);
    writeMask(8'h01);
    expectVal("R7", 1, 8'h01);
    readReg(1'b1, "R6", 8'h01);

    // R9 pin routing ignores the mask
    @(negedge clk); pinRouteEn = 1'b1;
    @(posedge clk);
    expectVal("R9", 2, 8'h09); expectVal("R9", 3, 8'h01);
    @(negedge clk); pinRouteEn = 1'b0;
    @(posedge clk);
    expectVal("R9", 2, 8'h00); expectVal("R9", 3, 8'h00);

    // R3 sticky events, R8 unmasked read, R4 read clears
    setLevels(2'b00, 2'b00);
    pulseBrk(2'b10);
    idle(4);
    pulseCtr();
    idle(2);
    readReg(1'b0, "R8", 8'h48);
    readReg(1'b0, "R4", 8'h00);

    // R4 ready bits survive a read
    setLevels(2'b01, 2'b00);
    pulseBrk(2'b01);
    readReg(1'b0, "R3", 8'h05);
    readReg(1'b0, "R4", 8'h01);

    // R4 event colliding with a read is kept
    @(negedge clk); regSel = 1'b0; rdEn = 1'b1; brkChgIn = 2'b10;
    @(posedge clk); expectVal("R4", 0, 8'h01);
    @(negedge clk); rdEn = 1'b0; brkChgIn = 2'b00;
    readReg(1'b0, "R4", 8'h41);
    readReg(1'b0, "R4", 8'h01);

    // R5 clear strobe
    writeMask(8'h08);
    pulseCtr();
    expectVal("R7", 1, 8'h00);
    pulseClr();
    expectVal("R5", 1, 8'h01);
    expectVal("R5", 0, 8'h01);
    readReg(1'b0, "R5", 8'h01);

    // R10 input pin change, three edges to the status bit
    writeMask(8'h80);
    @(negedge clk); mpiPin = 1'b1;
    @(posedge clk); expectVal("R10", 1, 8'h01);
    @(posedge clk); expectVal("R10", 1, 8'h01);
    @(posedge clk); expectVal("R10", 1, 8'h00);
    readReg(1'b0, "R10", 8'h81);
    idle(5);
    readReg(1'b0, "R10", 8'h01);
    @(negedge clk); mpiPin = 1'b0;
    idle(3);
    expectVal("R10", 1, 8'h00);
    readReg(1'b0, "R10", 8'h81);
    expectVal("R10", 1, 8'h01);

    idle(2);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule